// File: doc/BRIEF.md
# Multi-port GPIO register bank

This block is a bus-attached general-purpose I/O controller. An APB requester reads and writes a fixed register map. The map gives each of up to four ports three things: an output value register, a direction register, and a read-only view of that port's pad inputs. A direction bit of 1 turns the pad driver on and sends the stored output bit to the pad. A direction bit of 0 turns the driver off, and the pad output then reads as 0. Pad inputs pass through two flip-flops before software can read them.

The first port also carries a set of interrupt configuration registers: enable, mask, edge/level select, polarity and debounce enable. The block only stores these and presents them on output pins to a separate interrupt unit. It does not detect interrupts itself. The interrupt unit returns a status vector, which software can read. A write to the acknowledge register produces a one-cycle pulse that carries the written bit pattern.

A build-time parameter selects one of two address layouts for the interrupt registers. The APB side has no back-pressure: every transfer completes in its access phase. There are no streaming interfaces. All pins are plain control and data signals.

Top module: `gpio_bank`

## Requirements
- R1: `pready` is always 1, so each transfer finishes in its access phase. `prdata` carries the addressed register while `psel` is high with `pwrite` low, and is 0 at all other times.
- R2: Port p has its output value register at byte offset 12·p and its direction register at 12·p+4. A write lands on the clock edge that ends the access phase, and a read returns the stored value.
- R3: For every line, `pad_oe` equals the direction bit. `pad_out` equals the output value bit when the direction bit is 1, and 0 when it is 0. Line i of port p is bit p·PORT_LINES+i of the pad vectors.
- R4: The pad-input view of port p is at offset 0x50+4·p. It returns the value `pad_in` had two rising edges before the read, and writes to it are ignored.
- R5: With ALT_MAP=0, the interrupt registers sit at these offsets: enable 0x30, mask 0x34, edge select 0x38, polarity 0x3C, status 0x40, debounce 0x48, acknowledge 0x4C.
- R6: With ALT_MAP=1, the offsets change as follows: mask moves to 0x44, edge select to 0x34, polarity to 0x38, status to 0x3C and acknowledge to 0x40. Enable stays at 0x30 and debounce at 0x48, and 0x4C is unmapped.
- R7: The status register reads back `irq_status_i` as it is, and writes to it are ignored.
- R8: A write to the acknowledge register drives `irq_eoi_o` with the low PORT_LINES bits of `pwdata` for exactly the access-phase cycle. `irq_eoi_o` is 0 at all other times, and the register reads as 0.
- R9: Reads of any offset not named in R2, R4–R7 return 0, including unaligned offsets. Writes to such offsets change no register or output.
- R10: Bits PORT_LINES and above read as 0 in every register.
- R11: After reset, every stored register, `pad_out`, `pad_oe` and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied to 1 |
| pad_in | input | NUM_PORTS·PORT_LINES | Pad input levels |
| pad_out | output | NUM_PORTS·PORT_LINES | Pad output levels |
| pad_oe | output | NUM_PORTS·PORT_LINES | Pad output enables |
| irq_status_i | input | PORT_LINES | Status from the interrupt unit |
| irq_enable_o | output | PORT_LINES | Interrupt enable bits |
| irq_mask_o | output | PORT_LINES | Interrupt mask bits |
| irq_edge_o | output | PORT_LINES | 1 = edge sensitive, 0 = level sensitive |
| irq_polarity_o | output | PORT_LINES | 1 = high/rising, 0 = low/falling |
| irq_debounce_o | output | PORT_LINES | Debounce enable bits |
| irq_eoi_o | output | PORT_LINES | Acknowledge pulse bits |

## Verification
The assertions check on every cycle that:
- the pad view lags `pad_in` by exactly two edges;
- a write to an output value, direction or interrupt configuration register is on the pins one edge later;
- acknowledge pulses occur only during write access phases;
- the upper read-data bits stay 0.

Only the bench scenarios can show that each offset reaches the right register in both layouts, that write-only, read-only and unmapped offsets behave as required, and that the two layouts differ only where R6 says. For this, one bus drives a default-layout and an alternate-layout instance side by side, and a behavioural model is compared with both on every cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_DATA,
    RG_DIR,
    RG_EXT,
    RG_IEN,
    RG_IMASK,
    RG_IEDGE,
    RG_IPOL,
    RG_ISTAT,
    RG_IDEB,
    RG_IEOI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [1:0]  port;
  } reg_sel_t;

  localparam int BANK_STRIDE = 12;
  localparam int DIR_OFS     = 4;
  localparam int EXT_BASE    = 'h50;
  localparam int EXT_STRIDE  = 4;

  localparam int CFG_N    = 5;
  localparam int CFG_EN   = 0;
  localparam int CFG_MASK = 1;
  localparam int CFG_EDGE = 2;
  localparam int CFG_POL  = 3;
  localparam int CFG_DEB  = 4;

  function automatic reg_kind_e irq_map_std(input int ofs);
    case (ofs)
      'h30:    return RG_IEN;
      'h34:    return RG_IMASK;
      'h38:    return RG_IEDGE;
      'h3C:    return RG_IPOL;
      'h40:    return RG_ISTAT;
      'h48:    return RG_IDEB;
      'h4C:    return RG_IEOI;
      default: return RG_NONE;
    endcase
  endfunction

  function automatic reg_kind_e irq_map_alt(input int ofs);
    case (ofs)
      'h30:    return RG_IEN;
      'h34:    return RG_IEDGE;
      'h38:    return RG_IPOL;
      'h3C:    return RG_ISTAT;
      'h40:    return RG_IEOI;
      'h44:    return RG_IMASK;
      'h48:    return RG_IDEB;
      default: return RG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int NUM_PORTS = 4,
  parameter bit ALT_MAP   = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  reg_kind_e irq_kind;

  generate
    if (ALT_MAP) begin : g_alt_layout
      always_comb irq_kind = irq_map_alt(int'(addr));
    end else begin : g_std_layout
      always_comb irq_kind = irq_map_std(int'(addr));
    end
  endgenerate

  always_comb begin
    sel.kind = irq_kind;
    sel.port = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(addr) == p * BANK_STRIDE) begin
        sel.kind = RG_DATA;
        sel.port = 2'(p);
      end
      if (int'(addr) == p * BANK_STRIDE + DIR_OFS) begin
        sel.kind = RG_DIR;
        sel.port = 2'(p);
      end
      if (int'(addr) == EXT_BASE + p * EXT_STRIDE) begin
        sel.kind = RG_EXT;
        sel.port = 2'(p);
      end
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int LINES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data,
  input  logic             wr_dir,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe,
  output logic [LINES-1:0] data_q,
  output logic [LINES-1:0] dir_q,
  output logic [LINES-1:0] ext_q
);

  logic [LINES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      ext_q  <= '0;
    end else begin
      sync_q <= pad_in;
      ext_q  <= sync_q;
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = data_q & dir_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_EXT_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (ext_q == $past(pad_in, 2))); // R4
  AST_DATA_WRITE_TO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (pad_out == ($past(wdata) & pad_oe))); // R3
  AST_DIR_WRITE_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pad_oe == $past(wdata))); // R3

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_bank_pkg::*;
#(
  parameter int LINES = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CFG_N-1:0]            cfg_we,
  input  logic                        eoi_we,
  input  logic [LINES-1:0]            wdata,
  output logic [CFG_N-1:0][LINES-1:0] cfg_q,
  output logic [LINES-1:0]            eoi
);

  for (genvar k = 0; k < CFG_N; k++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[k] <= '0;
      else if (cfg_we[k]) cfg_q[k] <= wdata;
    end

    AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we[k] |=> (cfg_q[k] == $past(wdata))); // R5
  end

  assign eoi = eoi_we ? wdata : '0;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int PORT_LINES = 24,
  parameter int ADDR_W     = 7,
  parameter bit ALT_MAP    = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            psel,
  input  logic                            penable,
  input  logic                            pwrite,
  input  logic [ADDR_W-1:0]               paddr,
  input  logic [31:0]                     pwdata,
  output logic [31:0]                     prdata,
  output logic                            pready,
  input  logic [NUM_PORTS*PORT_LINES-1:0] pad_in,
  output logic [NUM_PORTS*PORT_LINES-1:0] pad_out,
  output logic [NUM_PORTS*PORT_LINES-1:0] pad_oe,
  input  logic [PORT_LINES-1:0]           irq_status_i,
  output logic [PORT_LINES-1:0]           irq_enable_o,
  output logic [PORT_LINES-1:0]           irq_mask_o,
  output logic [PORT_LINES-1:0]           irq_edge_o,
  output logic [PORT_LINES-1:0]           irq_polarity_o,
  output logic [PORT_LINES-1:0]           irq_debounce_o,
  output logic [PORT_LINES-1:0]           irq_eoi_o
);

  localparam int LW = PORT_LINES;

  reg_sel_t sel;
  logic     wr_cycle;
  logic     unused_wdata_bits;

  logic [NUM_PORTS-1:0][LW-1:0] data_q, dir_q, ext_q;
  logic [CFG_N-1:0][LW-1:0]     cfg_q;
  logic [CFG_N-1:0]             cfg_we;
  logic                         eoi_we;
  logic [LW-1:0]                rd_val;

  assign pready            = 1'b1;
  assign wr_cycle          = psel & penable & pwrite;
  assign unused_wdata_bits = ^pwdata;

  gpio_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_PORTS(NUM_PORTS),
    .ALT_MAP  (ALT_MAP)
  ) u_decode (
    .addr(paddr),
    .sel (sel)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_cycle && (sel.port == 2'(p));

    gpio_port_regs #(.LINES(LW)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_data(hit && (sel.kind == RG_DATA)),
      .wr_dir (hit && (sel.kind == RG_DIR)),
      .wdata  (pwdata[LW-1:0]),
      .pad_in (pad_in[p*LW +: LW]),
      .pad_out(pad_out[p*LW +: LW]),
      .pad_oe (pad_oe[p*LW +: LW]),
      .data_q (data_q[p]),
      .dir_q  (dir_q[p]),
      .ext_q  (ext_q[p])
    );
  end

  always_comb begin
    cfg_we = '0;
    eoi_we = 1'b0;
    if (wr_cycle) begin
      case (sel.kind)
        RG_IEN:   cfg_we[CFG_EN]   = 1'b1;
        RG_IMASK: cfg_we[CFG_MASK] = 1'b1;
        RG_IEDGE: cfg_we[CFG_EDGE] = 1'b1;
        RG_IPOL:  cfg_we[CFG_POL]  = 1'b1;
        RG_IDEB:  cfg_we[CFG_DEB]  = 1'b1;
        RG_IEOI:  eoi_we           = 1'b1;
        default: ;
      endcase
    end
  end

  gpio_irq_regs #(.LINES(LW)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg_we(cfg_we),
    .eoi_we(eoi_we),
    .wdata (pwdata[LW-1:0]),
    .cfg_q (cfg_q),
    .eoi   (irq_eoi_o)
  );

  assign irq_enable_o   = cfg_q[CFG_EN];
  assign irq_mask_o     = cfg_q[CFG_MASK];
  assign irq_edge_o     = cfg_q[CFG_EDGE];
  assign irq_polarity_o = cfg_q[CFG_POL];
  assign irq_debounce_o = cfg_q[CFG_DEB];

  always_comb begin
    rd_val = '0;
    case (sel.kind)
      RG_IEN:   rd_val = cfg_q[CFG_EN];
      RG_IMASK: rd_val = cfg_q[CFG_MASK];
      RG_IEDGE: rd_val = cfg_q[CFG_EDGE];
      RG_IPOL:  rd_val = cfg_q[CFG_POL];
      RG_IDEB:  rd_val = cfg_q[CFG_DEB];
      RG_ISTAT: rd_val = irq_status_i;
      default: ;
    endcase
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel.port == 2'(p)) begin
        case (sel.kind)
          RG_DATA: rd_val = data_q[p];
          RG_DIR:  rd_val = dir_q[p];
          RG_EXT:  rd_val = ext_q[p];
          default: ;
        endcase
      end
    end
    prdata = (psel && !pwrite) ? 32'(rd_val) : 32'd0;
  end

  AST_EOI_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_eoi_o) |-> (psel && penable && pwrite)); // R8

  if (LW < 32) begin : g_upper_zero
    AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      psel |-> (prdata[31:LW] == '0)); // R10
  end

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

  localparam int NP = 4;
  localparam int LW = 24;
  localparam int PW = NP * LW;
  localparam int K_NONE = 0, K_DR = 1, K_DDR = 2, K_EXT = 3, K_EN = 4, K_MSK = 5,
                 K_TYP = 6, K_POL = 7, K_ST = 8, K_DEB = 9, K_EOI = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [PW-1:0] pad_in = '0;
  logic [LW-1:0] irq_status = '0;

  logic [31:0]   rd_w [2];
  logic          rdy_w [2];
  logic [PW-1:0] out_w [2], oe_w [2];
  logic [LW-1:0] en_w [2], msk_w [2], typ_w [2], pol_w [2], deb_w [2], eoi_w [2];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .PORT_LINES(LW), .ADDR_W(7), .ALT_MAP(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(rd_w[0]), .pready(rdy_w[0]),
    .pad_in(pad_in), .pad_out(out_w[0]), .pad_oe(oe_w[0]), .irq_status_i(irq_status),
    .irq_enable_o(en_w[0]), .irq_mask_o(msk_w[0]), .irq_edge_o(typ_w[0]),
    .irq_polarity_o(pol_w[0]), .irq_debounce_o(deb_w[0]), .irq_eoi_o(eoi_w[0]));

  gpio_bank #(.NUM_PORTS(NP), .PORT_LINES(LW), .ADDR_W(7), .ALT_MAP(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(rd_w[1]), .pready(rdy_w[1]),
    .pad_in(pad_in), .pad_out(out_w[1]), .pad_oe(oe_w[1]), .irq_status_i(irq_status),
    .irq_enable_o(en_w[1]), .irq_mask_o(msk_w[1]), .irq_edge_o(typ_w[1]),
    .irq_polarity_o(pol_w[1]), .irq_debounce_o(deb_w[1]), .irq_eoi_o(eoi_w[1]));

  // Behavioural model of the register map (from the requirements)
  logic [LW-1:0] m_dr  [2][NP];
  logic [LW-1:0] m_ddr [2][NP];
  logic [LW-1:0] m_cfg [2][16];
  logic [PW-1:0] m_s1, m_ext;

  function automatic int kind_of(input bit alt, input int a);
    for (int p = 0; p < NP; p++) begin
      if (a == 12 * p)     return K_DR;
      if (a == 12 * p + 4) return K_DDR;
      if (a == 80 + 4 * p) return K_EXT;
    end
    if (!alt) begin
      case (a)
        48: return K_EN;  52: return K_MSK; 56: return K_TYP; 60: return K_POL;
        64: return K_ST;  72: return K_DEB; 76: return K_EOI;
        default: return K_NONE;
      endcase
    end
    case (a)
      48: return K_EN;  52: return K_TYP; 56: return K_POL; 60: return K_ST;
      64: return K_EOI; 68: return K_MSK; 72: return K_DEB;
      default: return K_NONE;
    endcase
  endfunction

  function automatic int port_of(input int a);
    return (a < 48) ? a / 12 : (a - 80) / 4;
  endfunction

  function automatic string tag_of(input int k, input bit alt);
    case (k)
      K_DR, K_DDR: return "R2";
      K_EXT:       return "R4";
      K_ST:        return "R7";
      K_EOI:       return "R8";
      K_NONE:      return "R9";
      default:     return alt ? "R6" : "R5";
    endcase
  endfunction

  function automatic logic [LW-1:0] model_rd(input int i);
    int k, p;
    k = kind_of(i[0], int'(paddr));
    p = port_of(int'(paddr));
    case (k)
      K_DR:  return m_dr[i][p];
      K_DDR: return m_ddr[i][p];
      K_EXT: return m_ext[p*LW +: LW];
      K_ST:  return irq_status;
      K_EN, K_MSK, K_TYP, K_POL, K_DEB: return m_cfg[i][k];
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1  <= '0;
      m_ext <= '0;
      for (int i = 0; i < 2; i++) begin
        for (int p = 0; p < NP; p++) begin
          m_dr[i][p]  <= '0;
          m_ddr[i][p] <= '0;
        end
        for (int k = 0; k < 16; k++) m_cfg[i][k] <= '0;
      end
    end else begin
      m_s1  <= pad_in;
      m_ext <= m_s1;
      if (psel && penable && pwrite) begin
        for (int i = 0; i < 2; i++) begin
          int k, p;
          k = kind_of(i[0], int'(paddr));
          p = port_of(int'(paddr));
          case (k)
            K_DR:  m_dr[i][p]  <= pwdata[LW-1:0];
            K_DDR: m_ddr[i][p] <= pwdata[LW-1:0];
            K_EN, K_MSK, K_TYP, K_POL, K_DEB: m_cfg[i][k] <= pwdata[LW-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison, 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      for (int i = 0; i < 2; i++) begin
        logic [PW-1:0] e_oe, e_out;
        logic [LW-1:0] e_eoi;
        logic [31:0]   e_rd;
        int k;
        k = kind_of(i[0], int'(paddr));
        for (int p = 0; p < NP; p++) begin
          e_oe[p*LW +: LW]  = m_ddr[i][p];
          e_out[p*LW +: LW] = m_dr[i][p] & m_ddr[i][p];
        end
        e_rd  = (psel && !pwrite) ? 32'(model_rd(i)) : 32'd0;
        e_eoi = (psel && penable && pwrite && k == K_EOI) ? pwdata[LW-1:0] : '0;
        chk(rdy_w[i] === 1'b1, "R1 pready", 128'(rdy_w[i]), 128'd1);
        chk(rd_w[i] === e_rd, (psel && !pwrite) ? tag_of(k, i[0]) : "R1 idle prdata",
            128'(rd_w[i]), 128'(e_rd));
        if (psel) chk(rd_w[i][31:LW] === '0, "R10 upper read bits", 128'(rd_w[i]), 128'(e_rd));
        chk(oe_w[i] === e_oe, "R3 pad_oe", 128'(oe_w[i]), 128'(e_oe));
        chk(out_w[i] === e_out, "R3 pad_out", 128'(out_w[i]), 128'(e_out));
        chk(eoi_w[i] === e_eoi, "R8 eoi pulse", 128'(eoi_w[i]), 128'(e_eoi));
        chk({en_w[i], msk_w[i], typ_w[i], pol_w[i], deb_w[i]} ===
            {m_cfg[i][K_EN], m_cfg[i][K_MSK], m_cfg[i][K_TYP], m_cfg[i][K_POL], m_cfg[i][K_DEB]},
            i ? "R6 irq config pins" : "R5 irq config pins",
            128'({en_w[i], msk_w[i], typ_w[i], pol_w[i], deb_w[i]}),
            128'({m_cfg[i][K_EN], m_cfg[i][K_MSK], m_cfg[i][K_TYP], m_cfg[i][K_POL], m_cfg[i][K_DEB]}));
      end
    end
  end

  task automatic apb(input bit wr, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state at the pins
    for (int i = 0; i < 2; i++)
      chk((oe_w[i] | out_w[i]) === '0 && (en_w[i] | msk_w[i] | typ_w[i] | pol_w[i] | deb_w[i] | eoi_w[i]) === '0,
          "R11 reset outputs", 128'(oe_w[i]), 128'd0);
    rst_n = 1'b1;
    for (int p = 0; p < NP; p++) apb(1'b0, 7'(12 * p), 0);   // R11 reads after reset

    // R2 / R3: output value and direction patterns per port
    for (int p = 0; p < NP; p++) begin
      apb(1'b1, 7'(12 * p),     32'hFFFF_FFFF ^ (32'h0011_2233 << p));
      apb(1'b1, 7'(12 * p + 4), 32'h00F0_F0F0 >> p);
      apb(1'b0, 7'(12 * p), 0);
      apb(1'b0, 7'(12 * p + 4), 0);
    end

    // R4: pad view after synchronizer, writes ignored
    pad_in = {32'hDEAD_BEEF, 32'h1234_5678, 32'hA5C3_0F96};
    for (int p = 0; p < NP; p++) begin
      apb(1'b1, 7'(80 + 4 * p), 32'hFFFF_FFFF);
      apb(1'b0, 7'(80 + 4 * p), 0);
      pad_in = ~pad_in;
    end

    // R5 / R6 / R7 / R8: interrupt block in both layouts
    irq_status = 24'h5A_3C_81;
    for (int a = 48; a <= 76; a += 4) apb(1'b1, 7'(a), 32'hA5A5_A5A5 ^ (a * 32'h0101_0101));
    for (int a = 48; a <= 76; a += 4) apb(1'b0, 7'(a), 0);
    irq_status = 24'hC3_00_7E;
    apb(1'b0, 7'd64, 0);
    apb(1'b0, 7'd60, 0);

    // R9: unmapped, unaligned and holes
    apb(1'b1, 7'd8, 32'hFFFF_FFFF);
    apb(1'b1, 7'd44, 32'hFFFF_FFFF);
    apb(1'b1, 7'd96, 32'hFFFF_FFFF);
    apb(1'b1, 7'd1, 32'hFFFF_FFFF);
    apb(1'b1, 7'd124, 32'hFFFF_FFFF);
    apb(1'b0, 7'd8, 0);
    apb(1'b0, 7'd1, 0);
    apb(1'b0, 7'd124, 0);

    // Mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [6:0] a;
      a = ($urandom_range(0, 9) == 0) ? 7'($urandom) : 7'($urandom_range(0, 31) * 4);
      pad_in = {$urandom, $urandom, $urandom};
      irq_status = 24'($urandom);
      apb(1'($urandom), a, $urandom);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule